// File: doc/BRIEF.md
# Step-Down Regulator Control Register Interface over I2C

This block is the serial control front end of a programmable step-down regulator. It behaves as an I2C target at a fixed 7-bit address and owns a six-entry byte map. Three entries are read/write and drive the regulator's control logic: two voltage-select words, each with an enable bit, and one control word holding output discharge, slew rate and PWM/PFM mode. Two entries are fixed identification bytes. One entry is a status byte built from live flags supplied by the analog side, together with a sticky flag that records a soft reset.

The block samples SCL and SDA on the system clock through a small synchroniser and detects edges and bus conditions from the synchronised lines. A protocol state machine then walks through the address, pointer, data and acknowledge phases. The states are IDLE, ADDR, ADDR_ACK, REG, REG_ACK, WDATA, WDATA_ACK, RDATA, RDATA_ACK and IGNORE. A START condition sends any state to ADDR, and a STOP condition sends any state to IDLE. ADDR moves to ADDR_ACK when the address matches and to IGNORE when it does not. ADDR_ACK moves to REG for a write and to RDATA for a read. REG moves to REG_ACK, then to WDATA. WDATA and WDATA_ACK alternate for each byte written. RDATA and RDATA_ACK alternate for each byte read while the master acknowledges. A master NACK moves the machine to IGNORE. The SDA pin is open-drain and is modelled as an active-high pull-down enable.

Top module: `vreg_ctl_i2c`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits are 0x60, with the read/write flag in bit 0. Any other address byte, including the high-speed master code 00001xxx, is left unacknowledged. The target then ignores the rest of that transfer until the next START.
- R2: In a write, the byte after the address loads the register pointer. Each following byte is written to the register the pointer selects. The target acknowledges every byte. Bits arrive MSB first and are sampled on the rising edge of SCL.
- R3: A read is an address byte with the write flag, a pointer byte, a repeated START, and an address byte with the read flag. The target then shifts out register bytes MSB first and changes SDA only after SCL falls. A master NACK ends the read and releases SDA.
- R4: The register pointer advances by one after every data byte, both in writes and in reads.
- R5: After reset, register 0x00 reads 0xD4, register 0x01 reads 0xCD, register 0x02 reads 0x80, register 0x03 reads 0x85, register 0x04 reads 0x00 and register 0x05 reads 0x00 when all status inputs are low.
- R6: In registers 0x00 and 0x01, bit 7 appears on the enable output and bits 6:0 appear on the code output. In register 0x02, bit 7 drives discharge, bits 6:4 drive slew and bits 1:0 drive mode. Bits 3 and 2 of register 0x02 always read 0.
- R7: Writing register 0x02 with bit 2 set returns registers 0x00 to 0x02 to their reset values.
- R8: Bit 2 of register 0x05 is set by a soft reset and cleared once register 0x05 has been read.
- R9: Register 0x05 reads {pgood, uvlo, ovp, rising, falling, reset flag, thermal, active} from bit 7 down to bit 0, with the live bits taken from the status inputs.
- R10: Writes to registers 0x03 to 0x05 and to unmapped addresses are acknowledged but change nothing. Reads of unmapped addresses return 0x00.
- R11: SDA is pulled low only during an acknowledge slot or for a 0 data bit of a read. It is released at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sta_pgood | input | 1 | Live status: output in regulation |
| sta_uvlo | input | 1 | Live status: input under-voltage |
| sta_ovp | input | 1 | Live status: input over-voltage |
| sta_rising | input | 1 | Live status: upward transition in progress |
| sta_falling | input | 1 | Live status: downward transition in progress |
| sta_thermal | input | 1 | Live status: thermal shutdown active |
| sta_active | input | 1 | Live status: converter running |
| en_sel0 | output | 1 | Enable bit of voltage word 0 |
| code_sel0 | output | 7 | Voltage code of word 0 |
| en_sel1 | output | 1 | Enable bit of voltage word 1 |
| code_sel1 | output | 7 | Voltage code of word 1 |
| dischg_on | output | 1 | Output discharge enable |
| slew_sel | output | 3 | Upward slew-rate select |
| mode_sel | output | 2 | PWM/PFM mode bits |

## Verification
The hardest case to reach is the sticky reset flag in the status byte. It only changes after a soft-reset write, and it only clears as a side effect of a read, so the stimulus has to chain transfers. The bench first programs non-default values over a sweep of write patterns. It then issues the soft reset, reads register 0x05 once and expects the flag set, and reads it again and expects it clear. Unacknowledged addresses, including the high-speed master code, are driven through a full multi-byte write so that the bench can confirm that none of the trailing bytes is acknowledged or stored.

// File: rtl/vreg_ctl_pkg.sv
package vreg_ctl_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] DEF_SEL0  = 8'hD4;
    localparam logic [7:0] DEF_SEL1  = 8'hCD;
    localparam logic [7:0] DEF_CTRL  = 8'h80;
    localparam logic [7:0] ID_WORD   = 8'h85;
    localparam logic [7:0] REV_WORD  = 8'h00;
    localparam logic [7:0] CTRL_KEEP = 8'hF3;
    localparam int         CTRL_RST_BIT = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tgt_state_t;

    typedef struct packed {
        logic pgood;
        logic uvlo;
        logic ovp;
        logic rising;
        logic falling;
        logic thermal;
        logic active;
    } live_status_t;

endpackage

// File: rtl/vreg_i2c_sense.sv
module vreg_i2c_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_s
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sy;
    logic [SYNC_STAGES-1:0] sda_sy;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[TOP-1:0], scl_i};
            sda_sy <= {sda_sy[TOP-1:0], sda_i};
            scl_q  <= scl_sy[TOP];
            sda_q  <= sda_sy[TOP];
        end
    end

    assign scl_s    = scl_sy[TOP];
    assign sda_s    = sda_sy[TOP];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/vreg_i2c_fsm.sv
module vreg_i2c_fsm
    import vreg_ctl_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       sda_s,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic       rd_stb,
    output logic [7:0] reg_ptr,
    output logic [7:0] wr_byte
);

    localparam int BIT_CW = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] CNT_FULL = BIT_CW'(BYTE_W);
    localparam logic [BIT_CW-1:0] CNT_LAST = BIT_CW'(BYTE_W - 1);

    tgt_state_t        state;
    tgt_state_t        nxt;
    logic [BIT_CW-1:0] bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic              rw_q;
    logic              mnack;
    logic              rx_full;
    logic              tx_last;
    logic              addr_hit;

    assign rx_full  = (bitcnt == CNT_FULL);
    assign tx_last  = (bitcnt == CNT_LAST);
    assign addr_hit = (shreg[7:1] == TARGET_ADDR);
    assign wr_byte  = shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_ADDR:      if (scl_fall && rx_full) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_REG;
                ST_REG:       if (scl_fall && rx_full) nxt = ST_REG_ACK;
                ST_REG_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && rx_full) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && tx_last) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = mnack ? ST_IGNORE : ST_RDATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        unique case (state)
            ST_ADDR_ACK: begin
                sda_oe = 1'b1;
                rd_stb = scl_fall & rw_q;
            end
            ST_REG_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_WDATA:     wr_stb = scl_fall & rx_full;
            ST_RDATA:     sda_oe = ~txreg[7];
            ST_RDATA_ACK: rd_stb = scl_fall & ~mnack;
            default: begin
                sda_oe = 1'b0;
            end
        endcase
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            txreg   <= '1;
            rw_q    <= 1'b0;
            mnack   <= 1'b1;
            reg_ptr <= '0;
        end else if (start_ev || stop_ev) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise && !rx_full) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (scl_fall && rx_full) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) rw_q    <= shreg[0];
                        if (state == ST_REG)  reg_ptr <= shreg;
                    end
                end
                ST_WDATA_ACK: if (scl_fall) reg_ptr <= reg_ptr + 8'd1;
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_q) begin
                        txreg   <= rd_byte;
                        reg_ptr <= reg_ptr + 8'd1;
                        bitcnt  <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (tx_last) begin
                            bitcnt <= '0;
                        end else begin
                            txreg  <= {txreg[6:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) mnack <= sda_s;
                    if (scl_fall && !mnack) begin
                        txreg   <= rd_byte;
                        reg_ptr <= reg_ptr + 8'd1;
                    end
                end
                default: bitcnt <= bitcnt;
            endcase
        end
    end

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR)); // R1

    AST_QUIET_WHEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe); // R11

    AST_PTR_STEP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK && scl_fall && !start_ev && !stop_ev)
        |=> (reg_ptr == 8'($past(reg_ptr) + 8'd1))); // R4

    AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA_ACK && scl_fall && mnack && !start_ev && !stop_ev)
        |=> !sda_oe); // R3

endmodule

// File: rtl/vreg_regfile.sv
module vreg_regfile
    import vreg_ctl_pkg::*;
#(
    parameter int NUM_RW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic         rd_stb,
    input  logic [7:0]   addr,
    input  logic [7:0]   wr_data,
    input  live_status_t live,
    output logic [7:0]   rd_data,
    output logic         en_sel0,
    output logic [6:0]   code_sel0,
    output logic         en_sel1,
    output logic [6:0]   code_sel1,
    output logic         dischg_on,
    output logic [2:0]   slew_sel,
    output logic [1:0]   mode_sel
);

    localparam logic [7:0] CTRL_ADDR = 8'(NUM_RW - 1);
    localparam logic [7:0] ID_ADDR   = 8'(NUM_RW);
    localparam logic [7:0] REV_ADDR  = 8'(NUM_RW + 1);
    localparam logic [7:0] MON_ADDR  = 8'(NUM_RW + 2);

    function automatic logic [7:0] def_byte(input int idx);
        case (idx)
            0:       def_byte = DEF_SEL0;
            1:       def_byte = DEF_SEL1;
            default: def_byte = DEF_CTRL;
        endcase
    endfunction

    function automatic logic [7:0] keep_mask(input int idx);
        keep_mask = (idx == NUM_RW - 1) ? CTRL_KEEP : 8'hFF;
    endfunction

    logic [7:0] rw_reg [NUM_RW];
    logic       rst_flag;
    logic       soft_rst;
    logic [7:0] mon_byte;

    assign soft_rst = wr_stb && (addr == CTRL_ADDR) && wr_data[CTRL_RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RW; i++) rw_reg[i] <= def_byte(i);
        end else if (soft_rst) begin
            for (int i = 0; i < NUM_RW; i++) rw_reg[i] <= def_byte(i);
        end else if (wr_stb) begin
            for (int i = 0; i < NUM_RW; i++)
                if (addr == 8'(i)) rw_reg[i] <= wr_data & keep_mask(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          rst_flag <= 1'b0;
        else if (soft_rst)                   rst_flag <= 1'b1;
        else if (rd_stb && addr == MON_ADDR) rst_flag <= 1'b0;
    end

    assign mon_byte = {live.pgood, live.uvlo, live.ovp, live.rising,
                       live.falling, rst_flag, live.thermal, live.active};

    always_comb begin
        rd_data = 8'h00;
        if (addr < 8'(NUM_RW)) begin
            for (int i = 0; i < NUM_RW; i++)
                if (addr == 8'(i)) rd_data = rw_reg[i];
        end else if (addr == ID_ADDR) begin
            rd_data = ID_WORD;
        end else if (addr == REV_ADDR) begin
            rd_data = REV_WORD;
        end else if (addr == MON_ADDR) begin
            rd_data = mon_byte;
        end
    end

    assign en_sel0   = rw_reg[0][7];
    assign code_sel0 = rw_reg[0][6:0];
    assign en_sel1   = rw_reg[1][7];
    assign code_sel1 = rw_reg[1][6:0];
    assign dischg_on = rw_reg[NUM_RW-1][7];
    assign slew_sel  = rw_reg[NUM_RW-1][6:4];
    assign mode_sel  = rw_reg[NUM_RW-1][1:0];

    AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ({en_sel0, code_sel0} == DEF_SEL0 && {en_sel1, code_sel1} == DEF_SEL1
                      && dischg_on == DEF_CTRL[7] && slew_sel == DEF_CTRL[6:4]
                      && mode_sel == DEF_CTRL[1:0])); // R7

    AST_RESET_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> rst_flag); // R8

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && addr == MON_ADDR && !wr_stb) |=> !rst_flag); // R8

    AST_RO_WRITE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr >= ID_ADDR)
        |=> $stable({en_sel0, code_sel0, en_sel1, code_sel1, dischg_on, slew_sel, mode_sel})); // R10

endmodule

// File: rtl/vreg_ctl_i2c.sv
module vreg_ctl_i2c
    import vreg_ctl_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h60,
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_RW      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       sta_pgood,
    input  logic       sta_uvlo,
    input  logic       sta_ovp,
    input  logic       sta_rising,
    input  logic       sta_falling,
    input  logic       sta_thermal,
    input  logic       sta_active,
    output logic       en_sel0,
    output logic [6:0] code_sel0,
    output logic       en_sel1,
    output logic [6:0] code_sel1,
    output logic       dischg_on,
    output logic [2:0] slew_sel,
    output logic [1:0] mode_sel
);

    logic         scl_rise;
    logic         scl_fall;
    logic         start_ev;
    logic         stop_ev;
    logic         sda_s;
    logic         wr_stb;
    logic         rd_stb;
    logic [7:0]   reg_ptr;
    logic [7:0]   wr_byte;
    logic [7:0]   rd_byte;
    live_status_t live;

    assign live = '{pgood: sta_pgood, uvlo: sta_uvlo, ovp: sta_ovp,
                    rising: sta_rising, falling: sta_falling,
                    thermal: sta_thermal, active: sta_active};

    vreg_i2c_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (sda_s)
    );

    vreg_i2c_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (sda_s),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .reg_ptr  (reg_ptr),
        .wr_byte  (wr_byte)
    );

    vreg_regfile #(.NUM_RW(NUM_RW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .addr      (reg_ptr),
        .wr_data   (wr_byte),
        .live      (live),
        .rd_data   (rd_byte),
        .en_sel0   (en_sel0),
        .code_sel0 (code_sel0),
        .en_sel1   (en_sel1),
        .code_sel1 (code_sel1),
        .dischg_on (dischg_on),
        .slew_sel  (slew_sel),
        .mode_sel  (mode_sel)
    );

endmodule

// File: tb/vreg_ctl_i2c_test.sv
`timescale 1ns/1ps
module vreg_ctl_i2c_test;

    localparam int Q = 8;
    localparam logic [7:0] AW = 8'hC0;
    localparam logic [7:0] AR = 8'hC1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic bus_sda;
    logic s_pg = 0, s_uv = 0, s_ov = 0, s_ri = 0, s_fa = 0, s_th = 0, s_ac = 0;
    logic       en0, en1, dis;
    logic [6:0] c0, c1;
    logic [2:0] slew;
    logic [1:0] mode;

    assign bus_sda = m_sda & ~sda_oe;

    vreg_ctl_i2c uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(sda_oe),
        .sta_pgood(s_pg), .sta_uvlo(s_uv), .sta_ovp(s_ov), .sta_rising(s_ri),
        .sta_falling(s_fa), .sta_thermal(s_th), .sta_active(s_ac),
        .en_sel0(en0), .code_sel0(c0), .en_sel1(en1), .code_sel1(c1),
        .dischg_on(dis), .slew_sel(slew), .mode_sel(mode)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = bus_sda; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(Q); b[i] = bus_sda; wq(Q); m_scl = 1'b0;
        end
        wq(Q); m_sda = last; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    // ackv bit 0 = address, bit 1 = pointer, bit 2+i = data byte i (0 = ACK)
    task automatic wr_burst(input logic [7:0] abyte, input logic [7:0] ptr, input int n,
                            output logic [9:0] ackv);
        logic a;
        ackv = '1;
        bus_start();
        send_byte(abyte, a); ackv[0] = a;
        send_byte(ptr, a);   ackv[1] = a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); ackv[2+i] = a;
        end
        bus_stop();
        wq(4);
    endtask

    task automatic rd_burst(input logic [7:0] ptr, input int n, output logic released);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(AW, a);
        send_byte(ptr, a);
        bus_start();
        send_byte(AR, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b); rbuf[i] = b;
        end
        wq(Q);
        released = ~sda_oe;
        bus_stop();
        wq(4);
    endtask

    function automatic logic [7:0] mon_exp(input logic rflag);
        return {s_pg, s_uv, s_ov, s_ri, s_fa, rflag, s_th, s_ac};
    endfunction

    task automatic chk_outputs(input string tag, input logic [7:0] v0, input logic [7:0] v1,
                               input logic [7:0] v2);
        chk({tag, " R6 sel0"}, {24'd0, en0, c0}, {24'd0, v0});
        chk({tag, " R6 sel1"}, {24'd0, en1, c1}, {24'd0, v1});
        chk({tag, " R6 ctrl"}, {26'd0, dis, slew, mode}, {26'd0, v2[7], v2[6:4], v2[1:0]});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [9:0] ackv;
        logic       rel;
        logic [7:0] v0, v1, v2, v7;
        wq(10);
        rst_n = 1'b1;
        wq(10);

        // R5 reset state at the outputs, R11 bus released
        chk_outputs("R5 reset", 8'hD4, 8'hCD, 8'h80);
        chk("R11 idle release", {31'd0, sda_oe}, 32'd0);

        // R5 R10 R4 R3 burst read of the whole map plus one unmapped byte
        rd_burst(8'h00, 7, rel);
        chk("R5 reg0", {24'd0, rbuf[0]}, 32'hD4);
        chk("R5 reg1", {24'd0, rbuf[1]}, 32'hCD);
        chk("R5 reg2", {24'd0, rbuf[2]}, 32'h80);
        chk("R5 reg3", {24'd0, rbuf[3]}, 32'h85);
        chk("R5 reg4", {24'd0, rbuf[4]}, 32'h00);
        chk("R5 reg5", {24'd0, rbuf[5]}, 32'h00);
        chk("R10 unmapped read", {24'd0, rbuf[6]}, 32'h00);
        chk("R3 nack release", {31'd0, rel}, 32'd1);

        // R9 monitor layout over a sweep of live status patterns
        for (int p = 0; p < 16; p++) begin
            v7 = (p == 15) ? 8'h7F : 8'((p * 37 + 3) & 8'h7F);
            {s_pg, s_uv, s_ov, s_ri, s_fa, s_th, s_ac} = v7[6:0];
            wq(4);
            rd_burst(8'h05, 1, rel);
            chk("R9 monitor", {24'd0, rbuf[0]}, {24'd0, mon_exp(1'b0)});
        end
        {s_pg, s_uv, s_ov, s_ri, s_fa, s_th, s_ac} = 7'd0;

        // R2 R4 R6 write sweep of the three control words
        for (int i = 0; i < 12; i++) begin
            v0 = 8'(i * 53 + 17);
            v1 = 8'(i * 29 + 200);
            v2 = 8'(i * 71 + 9) & 8'hFB;
            wbuf[0] = v0; wbuf[1] = v1; wbuf[2] = v2;
            wr_burst(AW, 8'h00, 3, ackv);
            chk("R2 acks", {27'd0, ackv[4:0]}, 32'd0);
            chk_outputs("R2 sweep", v0, v1, v2);
            rd_burst(8'h00, 3, rel);
            chk("R4 read0", {24'd0, rbuf[0]}, {24'd0, v0});
            chk("R4 read1", {24'd0, rbuf[1]}, {24'd0, v1});
            chk("R6 read2 masked", {24'd0, rbuf[2]}, {24'd0, v2 & 8'hF3});
        end

        // R10 read-only and unmapped writes are acknowledged and discarded
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        wr_burst(AW, 8'h03, 3, ackv);
        chk("R10 ro acks", {27'd0, ackv[4:0]}, 32'd0);
        wbuf[0] = 8'h5A;
        wr_burst(AW, 8'h10, 1, ackv);
        chk("R10 unmapped ack", {29'd0, ackv[2:0]}, 32'd0);
        rd_burst(8'h03, 3, rel);
        chk("R10 id kept", {24'd0, rbuf[0]}, 32'h85);
        chk("R10 rev kept", {24'd0, rbuf[1]}, 32'h00);
        chk("R10 mon kept", {24'd0, rbuf[2]}, {24'd0, mon_exp(1'b0)});
        rd_burst(8'h10, 1, rel);
        chk("R10 unmapped zero", {24'd0, rbuf[0]}, 32'h00);
        chk_outputs("R10 ctl kept", v0, v1, v2);

        // R1 wrong address and high-speed master code are not acknowledged
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        wr_burst(8'hC2, 8'h00, 2, ackv);
        chk("R1 wrong addr nack", {28'd0, ackv[3:0]}, 32'hF);
        wr_burst(8'h08, 8'h00, 2, ackv);
        chk("R1 master code nack", {28'd0, ackv[3:0]}, 32'hF);
        chk_outputs("R1 ignored", v0, v1, v2);

        // R7 soft reset, R8 sticky flag cleared by a monitor read
        wbuf[0] = 8'h04;
        wr_burst(AW, 8'h02, 1, ackv);
        chk("R7 ack", {29'd0, ackv[2:0]}, 32'd0);
        chk_outputs("R7 defaults", 8'hD4, 8'hCD, 8'h80);
        rd_burst(8'h00, 3, rel);
        chk("R7 reg0", {24'd0, rbuf[0]}, 32'hD4);
        chk("R7 reg1", {24'd0, rbuf[1]}, 32'hCD);
        chk("R7 reg2 bit2 reads 0", {24'd0, rbuf[2]}, 32'h80);
        rd_burst(8'h05, 1, rel);
        chk("R8 flag set", {24'd0, rbuf[0]}, {24'd0, mon_exp(1'b1)});
        rd_burst(8'h05, 1, rel);
        chk("R8 flag cleared", {24'd0, rbuf[0]}, {24'd0, mon_exp(1'b0)});
        chk("R11 final release", {31'd0, sda_oe}, 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule